// File: doc/BRIEF.md
# Expansion Memory Bank Select Controller

This block is the controller that sits on one expansion memory bank in a bank-switched 8-bit system. The 64 KB CPU space is divided into eight 8 KB chunks. The bank owns any subset of them, and whenever the CPU addresses a chunk the bank owns, it raises a claim that overrides the home bank for that chunk. Software talks to the bank through three memory-mapped registers. A target register picks which bank number later accesses are aimed at. A chunk-ownership register is loaded only by the bank whose number matches the target. A third register has two meanings: while enumerating, it holds the bank number; in normal operation, it is a deselect mask broadcast to every bank.

Banks are numbered at start-up by a token that travels along a daisychain. In setup mode, the one bank that holds the token takes the number written to the dual-purpose register and then hands the token to the next bank. Banks numbered earlier get lower numbers, which software treats as higher interrupt priority when it polls the status bits in ascending order. Chunk ownership and the assigned number survive the system reset and are cleared only by the power-on reset. Because of this, a bank that holds chunk 0 keeps it across a system reset.

Top module: `xbank_ctrl`

## Requirements
- R1: A write to register 0x80 latches the target bank number. A read of 0x80 returns it.
- R2: A write to register 0x40 loads the 8-bit ownership byte only when the bank is numbered and the target equals its assigned number. Otherwise the write is ignored.
- R3: In setup mode, a write to register 0xA0 assigns the written value as the bank number only while the bank holds the token and is not yet numbered. Any other setup write to 0xA0 is ignored, and a number once assigned does not change.
- R4: dc_out_o is high while in setup mode once the bank is numbered, and is low whenever setup mode is off.
- R5: In normal mode, a write to 0xA0 clears every ownership bit that is set in the written byte. This happens whether or not the bank is targeted.
- R6: While sys_rst_i is high, register writes are ignored and the target number is cleared to 0. Ownership and the assigned number are kept.
- R7: claim_o equals ownership bit n, where n is cpu_chunk_i (address bits 15:13). Bit n set means the bank owns addresses n*0x2000 to n*0x2000+0x1FFF.
- R8: A read of 0xA0 by the targeted bank returns 0xFE while irq_i is high and 0xFF otherwise. A read of 0x40 by the targeted bank returns the ownership byte. Reads of an untargeted bank, or of any unmapped address, return 0xFF.
- R9: The power-on reset rst_ni clears ownership, the target number and the assigned number, and leaves the bank unnumbered.
- R10: dc_in_i passes through two flip-flops before it grants the token. A setup write issued one clock edge after dc_in_i rises is ignored. A setup write issued two edges after it takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_i | input | 1 | System reset, synchronous; keeps ownership |
| setup_i | input | 1 | Setup (enumeration) mode enable |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_rdata_o | output | 8 | Register read data, combinational |
| dc_in_i | input | 1 | Daisychain token in |
| dc_out_o | output | 1 | Daisychain token out |
| irq_i | input | 1 | Bank device interrupt request |
| cpu_chunk_i | input | 3 | CPU address bits 15:13 |
| claim_o | output | 1 | Chunk claim, overrides home bank |

## Verification
A register write takes effect on the rising edge that samples its strobe. The claim and the readback can therefore be checked at the next falling edge, because claim_o and reg_rdata_o are combinational from state and inputs. The token needs two rising edges after dc_in_i rises, and the bench issues setup writes after exactly one edge and after two edges to bracket that latency. dc_out_o follows one edge after the numbering write. Every check is taken at a falling edge or 1 ns after an input change, never at a rising edge.

// File: rtl/xbank_pkg.sv
package xbank_pkg;
  localparam int unsigned REG_AW = 8;
  localparam logic [REG_AW-1:0] ADDR_TARGET = 8'h80;
  localparam logic [REG_AW-1:0] ADDR_OWN    = 8'h40;
  localparam logic [REG_AW-1:0] ADDR_DUAL   = 8'hA0;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_TARGET,
    ACC_OWN,
    ACC_DUAL
  } acc_e;
endpackage

// File: rtl/xbank_dchain.sv
module xbank_dchain (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_i,
  input  logic setup_i,
  input  logic dc_in_i,
  input  logic numbered_i,
  output logic token_o,
  output logic dc_out_o
);
  logic dc_m_q, dc_s_q;

  // master/slave pair: token advances at most one bank per edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dc_m_q <= 1'b0;
      dc_s_q <= 1'b0;
    end else if (sys_rst_i) begin
      dc_m_q <= 1'b0;
      dc_s_q <= 1'b0;
    end else begin
      dc_m_q <= dc_in_i;
      dc_s_q <= dc_m_q;
    end
  end

  assign token_o  = setup_i & dc_s_q & ~numbered_i;
  assign dc_out_o = setup_i & numbered_i;
endmodule

// File: rtl/xbank_regs.sv
module xbank_regs
  import xbank_pkg::*;
#(
  parameter int unsigned NUM_CHUNKS = 8,
  parameter int unsigned DATA_W     = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sys_rst_i,
  input  logic                  setup_i,
  input  acc_e                  acc_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  token_i,
  input  logic                  irq_i,
  output logic [NUM_CHUNKS-1:0] own_o,
  output logic                  numbered_o,
  output logic [DATA_W-1:0]     rdata_o
);
  logic [NUM_CHUNKS-1:0] own_q;
  logic [DATA_W-1:0]     num_q, target_q;
  logic                  numbered_q;
  logic                  hit;

  assign hit = numbered_q && (target_q == num_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q      <= '0;
      num_q      <= '0;
      target_q   <= '0;
      numbered_q <= 1'b0;
    end else if (sys_rst_i) begin
      target_q <= '0;
    end else if (wr_i) begin
      unique case (acc_i)
        ACC_TARGET: target_q <= wdata_i;
        ACC_OWN:    if (hit) own_q <= wdata_i[NUM_CHUNKS-1:0];
        ACC_DUAL: begin
          if (setup_i) begin
            if (token_i) begin
              num_q      <= wdata_i;
              numbered_q <= 1'b1;
            end
          end else begin
            own_q <= own_q & ~wdata_i[NUM_CHUNKS-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '1;
    if (rd_i) begin
      unique case (acc_i)
        ACC_TARGET: rdata_o = target_q;
        ACC_OWN:    if (hit) rdata_o = DATA_W'(own_q);
        ACC_DUAL:   if (hit) rdata_o = {{(DATA_W-1){1'b1}}, ~irq_i};
        default:    rdata_o = '1;
      endcase
    end
  end

  assign own_o      = own_q;
  assign numbered_o = numbered_q;
endmodule

// File: rtl/xbank_claim.sv
module xbank_claim #(
  parameter int unsigned NUM_CHUNKS = 8,
  localparam int unsigned SEL_W     = $clog2(NUM_CHUNKS)
) (
  input  logic [NUM_CHUNKS-1:0] own_i,
  input  logic [SEL_W-1:0]      chunk_i,
  output logic                  claim_o
);
  logic [NUM_CHUNKS-1:0] hit;

  for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_chunk
    assign hit[g] = own_i[g] && (chunk_i == SEL_W'(g));
  end

  assign claim_o = |hit;
endmodule

// File: rtl/xbank_ctrl.sv
module xbank_ctrl
  import xbank_pkg::*;
#(
  parameter int unsigned NUM_CHUNKS = 8,
  parameter int unsigned DATA_W     = 8,
  localparam int unsigned SEL_W     = $clog2(NUM_CHUNKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_rst_i,
  input  logic              setup_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              dc_in_i,
  output logic              dc_out_o,
  input  logic              irq_i,
  input  logic [SEL_W-1:0]  cpu_chunk_i,
  output logic              claim_o
);
  acc_e                  acc;
  logic                  token_w, numbered_w;
  logic [NUM_CHUNKS-1:0] own_w;

  always_comb begin
    unique case (reg_addr_i)
      ADDR_TARGET: acc = ACC_TARGET;
      ADDR_OWN:    acc = ACC_OWN;
      ADDR_DUAL:   acc = ACC_DUAL;
      default:     acc = ACC_NONE;
    endcase
  end

  xbank_dchain u_dchain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sys_rst_i  (sys_rst_i),
    .setup_i    (setup_i),
    .dc_in_i    (dc_in_i),
    .numbered_i (numbered_w),
    .token_o    (token_w),
    .dc_out_o   (dc_out_o)
  );

  xbank_regs #(.NUM_CHUNKS(NUM_CHUNKS), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sys_rst_i  (sys_rst_i),
    .setup_i    (setup_i),
    .acc_i      (acc),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .wdata_i    (reg_wdata_i),
    .token_i    (token_w),
    .irq_i      (irq_i),
    .own_o      (own_w),
    .numbered_o (numbered_w),
    .rdata_o    (reg_rdata_o)
  );

  xbank_claim #(.NUM_CHUNKS(NUM_CHUNKS)) u_claim (
    .own_i   (own_w),
    .chunk_i (cpu_chunk_i),
    .claim_o (claim_o)
  );
endmodule

// File: rtl/xbank_ctrl_chk.sv
module xbank_ctrl_chk
  import xbank_pkg::*;
#(
  parameter int unsigned NUM_CHUNKS = 8,
  parameter int unsigned DATA_W     = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  sys_rst_i,
  input logic                  setup_i,
  input logic [REG_AW-1:0]     reg_addr_i,
  input logic [DATA_W-1:0]     reg_wdata_i,
  input logic                  reg_wr_i,
  input logic                  reg_rd_i,
  input logic [DATA_W-1:0]     reg_rdata_o,
  input logic                  dc_out_o,
  input logic                  claim_o,
  input logic [NUM_CHUNKS-1:0] own,
  input logic                  numbered
);
  AST_SYSRST_KEEPS_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i |=> own == $past(own)); // R6

  AST_DESELECT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !sys_rst_i && !setup_i && reg_addr_i == ADDR_DUAL)
      |=> ((own & $past(reg_wdata_i[NUM_CHUNKS-1:0])) == '0)); // R5

  AST_CHAIN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !setup_i |-> !dc_out_o); // R4

  AST_NUMBER_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    numbered |=> numbered); // R3

  AST_NUMBER_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(numbered) |-> $past(setup_i && reg_wr_i && reg_addr_i == ADDR_DUAL)); // R3

  AST_CLAIM_NEEDS_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o |-> own != '0); // R7

  AST_UNNUMBERED_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && !numbered && reg_addr_i == ADDR_DUAL) |-> reg_rdata_o == '1); // R8
endmodule

bind xbank_ctrl xbank_ctrl_chk #(.NUM_CHUNKS(NUM_CHUNKS), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sys_rst_i   (sys_rst_i),
  .setup_i     (setup_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_rdata_o (reg_rdata_o),
  .dc_out_o    (dc_out_o),
  .claim_o     (claim_o),
  .own         (own_w),
  .numbered    (numbered_w)
);

// File: tb/xbank_ctrl_bench.sv
module xbank_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0, sys_rst = 1'b0, setup = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic       wr = 1'b0, rd = 1'b0;
  logic       dc_in = 1'b0, dc_out, irq = 1'b0, claim;
  logic [2:0] chunk = '0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  xbank_ctrl u_xbank_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .sys_rst_i(sys_rst), .setup_i(setup),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_rdata_o(rdata), .dc_in_i(dc_in), .dc_out_o(dc_out), .irq_i(irq),
    .cpu_chunk_i(chunk), .claim_o(claim)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; write lands on the next rising edge
  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
    addr = a; rd = 1'b1;
    #1 check(req, rdata, exp);
    rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic claims_chk(string req, logic [7:0] exp);
    for (int c = 0; c < 8; c++) begin
      chunk = 3'(c);
      #1 check(req, claim, exp[c]);
    end
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9 reset state
    claims_chk("R9", 8'h00);
    check("R9 dc_out", dc_out, 0);
    rd_chk("R9 target", 8'h80, 8'h00);

    // R10 token needs two edges; R4 token pass
    setup = 1'b1; dc_in = 1'b1;
    @(negedge clk);
    wr_reg(8'hA0, 8'h03);
    check("R10 early write ignored", dc_out, 0);
    wr_reg(8'hA0, 8'h03);
    check("R4 token passed", dc_out, 1);
    // R3 renumbering ignored
    wr_reg(8'hA0, 8'h05);
    setup = 1'b0;
    #1 check("R4 idle out of setup", dc_out, 0);
    @(negedge clk);
    wr_reg(8'h80, 8'h05);
    wr_reg(8'h40, 8'hFF);
    claims_chk("R3 number kept", 8'h00);

    // R1 target latch
    wr_reg(8'h80, 8'h03);
    rd_chk("R1", 8'h80, 8'h03);

    // R2 R7 R8 sweep of ownership patterns
    for (int p = 0; p < 256; p++) begin
      wr_reg(8'h40, 8'(p));
      claims_chk("R7 R2", 8'(p));
      rd_chk("R8 own read", 8'h40, 8'(p));
    end

    // R2 mismatched target
    wr_reg(8'h40, 8'h5A);
    wr_reg(8'h80, 8'h04);
    wr_reg(8'h40, 8'hFF);
    claims_chk("R2 mismatch ignored", 8'h5A);
    rd_chk("R8 untargeted", 8'h40, 8'hFF);
    rd_chk("R8 untargeted status", 8'hA0, 8'hFF);

    // R5 deselect sweep, bank untargeted
    for (int d = 0; d < 256; d++) begin
      wr_reg(8'h80, 8'h03);
      wr_reg(8'h40, 8'hFF);
      wr_reg(8'h80, 8'h07);
      wr_reg(8'hA0, 8'(d));
      claims_chk("R5", ~8'(d));
    end

    // R8 status
    wr_reg(8'h80, 8'h03);
    irq = 1'b1;
    rd_chk("R8 irq", 8'hA0, 8'hFE);
    irq = 1'b0;
    rd_chk("R8 no irq", 8'hA0, 8'hFF);
    rd_chk("R8 unmapped", 8'h33, 8'hFF);

    // R6 system reset keeps ownership
    wr_reg(8'h40, 8'hC3);
    sys_rst = 1'b1;
    wr_reg(8'h40, 8'h00);
    sys_rst = 1'b0;
    claims_chk("R6 own kept", 8'hC3);
    rd_chk("R6 target cleared", 8'h80, 8'h00);
    wr_reg(8'h80, 8'h03);
    wr_reg(8'h40, 8'h81);
    claims_chk("R6 number kept", 8'h81);

    // R9 power-on reset
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    claims_chk("R9 own cleared", 8'h00);
    rd_chk("R9 target cleared", 8'h80, 8'h00);
    wr_reg(8'h80, 8'h03);
    wr_reg(8'h40, 8'hFF);
    claims_chk("R9 unnumbered", 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule